// File: doc/BRIEF.md
# Scannable "110" Sequence Recognizer

This block is a three-state Mealy machine that watches a serial bit stream and pulses a detect output for one cycle on the cycle in which the pattern 1, 1, 0 is completed. It is built for test access. Its two state flops are mux-D scan cells joined into a two-cell shift chain. A tester raises test enable and shifts a state in through scan-in. It then drops test enable for one or more functional capture cycles. Finally it raises test enable again and shifts the result out on scan-out. This lets the tester force and read any state, including the code 11, which normal operation never reaches.

The state encoding is fixed: S0 = 00, S1 = 01, S2 = 10. State bit 0 is the first cell after scan-in, and state bit 1 drives scan-out. The detect output is combinational. It depends on the present state and the present input.

Top module: `scan_seq_rec`

## Requirements
- R1: Codes are S0 = 2'b00, S1 = 2'b01 and S2 = 2'b10. When test enable is 0 and the state is S0, an input of 0 keeps the state at S0 and an input of 1 moves it to S1. In both cases detect is 0.
- R2: When test enable is 0 and the state is S1, an input of 1 moves the state to S2 and an input of 0 moves it to S0. In both cases detect is 0.
- R3: When test enable is 0 and the state is S2, an input of 1 keeps the state at S2 with detect 0. An input of 0 moves the state to S0 and drives detect to 1 in that same cycle. A run of 1, 1, 0 starting from S0 therefore gives exactly one detect pulse, on the 0.
- R4: When test enable is 0 and the state is the illegal code 2'b11, the next state is S0 and detect is 0, whatever the input.
- R5: A functional cycle with input 0 brings every one of the four codes to S0.
- R6: When test enable is 1, each clock loads state bit 0 from scan-in and state bit 1 from the old state bit 0. Scan-out always shows state bit 1. A full load therefore shifts the bit for state bit 1 first. A full unload reads scan-out, shifts once and reads scan-out again.
- R7: Detect is 0 whenever test enable is 1.
- R8: Synchronous reset forces the state to S0 at the next clock edge, and it takes priority over scan shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit |
| test_en | input | 1 | 1 selects scan shift, 0 selects functional capture |
| scan_in | input | 1 | Serial input to the chain, feeds state bit 0 |
| detect | output | 1 | One-cycle pulse when 1,1,0 completes |
| scan_out | output | 1 | End of the chain, equals state bit 1 |

## Verification
Two things can fall in the same cycle: a scan shift, and a present state and input that would raise detect. To provoke this, the bench loads S2, holds the input at 0 and keeps test enable high. It then judges that detect stays 0 and that the state moves as a shift and not as a transition. Reset and test enable also meet in one cycle. The bench loads S2, asserts both, and then checks through an unload that reset won.

// File: rtl/scan_seq_rec_pkg.sv
package scan_seq_rec_pkg;
  localparam int STATE_W = 2;
  typedef logic [STATE_W-1:0] code_t;
  localparam code_t ST_IDLE = 2'b00;
  localparam code_t ST_ONE  = 2'b01;
  localparam code_t ST_TWO  = 2'b10;
  localparam code_t ST_BAD  = 2'b11;

  function automatic code_t f_next(input code_t cur, input logic bit_in);
    code_t nx;
    case (cur)
      ST_IDLE: nx = bit_in ? ST_ONE : ST_IDLE;
      ST_ONE:  nx = bit_in ? ST_TWO : ST_IDLE;
      ST_TWO:  nx = bit_in ? ST_TWO : ST_IDLE;
      default: nx = ST_IDLE;
    endcase
    return nx;
  endfunction

  function automatic logic f_hit(input code_t cur, input logic bit_in);
    return (cur == ST_TWO) && !bit_in;
  endfunction
endpackage

// File: rtl/scan_seq_rec_next.sv
module scan_seq_rec_next
  import scan_seq_rec_pkg::*;
(
  input  code_t cur,
  input  logic  bit_in,
  output code_t nxt,
  output logic  hit
);
  always_comb begin
    nxt = f_next(cur, bit_in);
    hit = f_hit(cur, bit_in);
  end
endmodule

// File: rtl/scan_seq_rec_cell.sv
module scan_seq_rec_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_scan,
  input  logic d_func,
  input  logic d_scan,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= RST_VAL;
    else if (sel_scan) q <= d_scan;
    else               q <= d_func;
  end
endmodule

// File: rtl/scan_seq_rec.sv
module scan_seq_rec
  import scan_seq_rec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic test_en,
  input  logic scan_in,
  output logic detect,
  output logic scan_out
);
  localparam int CHAIN_LEN = STATE_W;

  code_t state_q;
  code_t state_nx;
  logic  func_hit;
  logic [CHAIN_LEN-1:0] chain_d;

  scan_seq_rec_next u_next (
    .cur    (state_q),
    .bit_in (din),
    .nxt    (state_nx),
    .hit    (func_hit)
  );

  genvar gi;
  generate
    for (gi = 0; gi < CHAIN_LEN; gi++) begin : g_chain
      if (gi == 0) begin : g_head
        assign chain_d[gi] = scan_in;
      end else begin : g_link
        assign chain_d[gi] = state_q[gi-1];
      end
      scan_seq_rec_cell #(.RST_VAL(ST_IDLE[gi])) u_cell (
        .clk      (clk),
        .rst      (rst),
        .sel_scan (test_en),
        .d_func   (state_nx[gi]),
        .d_scan   (chain_d[gi]),
        .q        (state_q[gi])
      );
    end
  endgenerate

  assign detect   = func_hit && !test_en;
  assign scan_out = state_q[CHAIN_LEN-1];
endmodule

// File: rtl/scan_seq_rec_chk.sv
module scan_seq_rec_chk
  import scan_seq_rec_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  din,
  input logic  test_en,
  input logic  scan_in,
  input logic  detect,
  input code_t state_q
);
  p_code11_recover_r4: assert property (@(posedge clk) disable iff (rst)
    (!test_en && state_q == ST_BAD) |=> (state_q == ST_IDLE));
  p_zero_init_r5: assert property (@(posedge clk) disable iff (rst)
    (!test_en && !din) |=> (state_q == ST_IDLE));
  p_shift_r6: assert property (@(posedge clk) disable iff (rst)
    test_en |=> (state_q == {$past(state_q[0]), $past(scan_in)}));
  p_quiet_scan_r7: assert property (@(posedge clk) disable iff (rst)
    test_en |-> !detect);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    detect |=> !detect);
  p_reset_idle_r8: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE));
endmodule

bind scan_seq_rec scan_seq_rec_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .test_en (test_en),
  .scan_in (scan_in),
  .detect  (detect),
  .state_q (state_q)
);

// File: tb/sim_scan_seq_rec.sv
module sim_scan_seq_rec;
  localparam int PERIOD = 10;
  localparam int NVEC = 8;
  // {code[1:0], din, next[1:0], detect}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b00_0_00_0, 6'b00_1_01_0, 6'b01_0_00_0, 6'b01_1_10_0,
    6'b10_0_00_1, 6'b10_1_10_0, 6'b11_0_00_0, 6'b11_1_00_0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic test_en = 1'b0;
  logic scan_in = 1'b0;
  logic detect, scan_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  scan_seq_rec u0 (
    .clk(clk), .rst(rst), .din(din), .test_en(test_en),
    .scan_in(scan_in), .detect(detect), .scan_out(scan_out)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic load(input logic [1:0] code);
    test_en = 1'b1; scan_in = code[1]; tick();
    scan_in = code[0]; tick();
    test_en = 1'b0;
  endtask

  task automatic unload(output logic [1:0] code);
    test_en = 1'b1;
    code[1] = scan_out; tick();
    code[0] = scan_out;
    test_en = 1'b0;
  endtask

  function automatic string tag_of(input logic [1:0] code);
    case (code)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    logic [1:0] got;
    tick(); tick();
    rst = 1'b0;
    #1;
    chk("R8 reset state", {1'b0, scan_out}, 2'b00);
    chk("R8 reset detect", {1'b0, detect}, 2'b00);
    unload(got);
    chk("R8 reset unload", got, 2'b00);

    // table walk: load, capture one cycle, unload
    for (int i = 0; i < NVEC; i++) begin
      load(VEC[i][5:4]);
      din = VEC[i][3];
      #1;
      chk({tag_of(VEC[i][5:4]), " detect"}, {1'b0, detect}, {1'b0, VEC[i][0]});
      tick();
      din = 1'b0;
      unload(got);
      chk({tag_of(VEC[i][5:4]), " next"}, got, VEC[i][2:1]);
    end

    // R6 shift round trip for every code, no capture
    for (int c = 0; c < 4; c++) begin
      load(c[1:0]);
      unload(got);
      chk("R6 shift round trip", got, c[1:0]);
    end

    // R5 zero initializes from each code
    for (int c = 0; c < 4; c++) begin
      load(c[1:0]);
      din = 1'b0; tick();
      unload(got);
      chk("R5 zero init", got, 2'b00);
    end

    // R3 stream 1,1,1,0 from S0: one pulse on the 0
    rst = 1'b1; tick(); rst = 1'b0;
    din = 1'b1; #1; chk("R3 stream b1", {1'b0, detect}, 2'b00); tick();
    din = 1'b1; #1; chk("R3 stream b2", {1'b0, detect}, 2'b00); tick();
    din = 1'b1; #1; chk("R3 stream b3", {1'b0, detect}, 2'b00); tick();
    din = 1'b0; #1; chk("R3 stream pulse", {1'b0, detect}, 2'b01); tick();
    din = 1'b0; #1; chk("R3 stream after", {1'b0, detect}, 2'b00); tick();

    // R7 shift and detect condition in the same cycle
    load(2'b10);
    test_en = 1'b1; din = 1'b0; scan_in = 1'b1; #1;
    chk("R7 detect masked", {1'b0, detect}, 2'b00);
    tick();
    // shift moved state 10 -> {0,1}
    unload(got);
    chk("R7 state shifted", got, 2'b01);

    // R8 reset wins over scan
    load(2'b10);
    rst = 1'b1; test_en = 1'b1; scan_in = 1'b1; tick();
    rst = 1'b0; test_en = 1'b0;
    unload(got);
    chk("R8 reset over scan", got, 2'b00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule